// File: doc/BRIEF.md
# ChaCha20 Stream Cipher XOR Engine

This engine encrypts or decrypts a byte stream with the ChaCha20 stream cipher. A single `start` pulse supplies a 256-bit key, a 128-bit counter-and-nonce group and a byte count. The engine then makes keystream one 64-byte block at a time. For each block it loads the 16-word state and runs twenty rounds, doing one quarter-round per clock. It adds the original state back to the result and XORs the keystream bytes, least-significant byte of each word first, with the bytes that arrive on the input stream.

The byte path has no storage. While a block is being emitted, an input byte goes straight to the output, XORed with the current keystream byte. Input ready follows output ready, and output valid follows input valid. After every full block the 32-bit block counter advances by one and a new permutation starts. A short final block uses only the bytes it needs. A request whose length is zero is dropped. The same operation serves for encryption and decryption.

Top module: `chacha_xor_engine`

## Requirements
- R1: After reset, and at any time the engine is idle, `busy`, `out_valid` and `in_ready` are 0.
- R2: The state words are laid out as follows:
  - Words 0..3 hold the constants 0x61707865, 0x3320646e, 0x79622d32 and 0x6b206574.
  - Word 4+i is `key[32*i+:32]` for i = 0..7.
  - Word 12+j is `ctr_nonce[32*j+:32]` for j = 0..3.
  - Keystream byte n of a block is bits `8*(n%4)+:8` of word n/4. Each word is the permuted word plus the original word, modulo 2^32.
  - The permutation is ten double rounds. Each double round is four column quarter-rounds followed by four diagonal quarter-rounds.
- R3: After each completed 64-byte block, word 12 increases by one modulo 2^32. No carry goes into word 13.
- R4: Exactly `msg_len` bytes are emitted. A final block shorter than 64 bytes stops after its last needed byte, and input offered after that byte is not accepted.
- R5: A `start` with `msg_len` = 0 leaves the engine idle and produces no output.
- R6: A `start` pulse while `busy` is 1 is ignored, together with its key and length, and the message in progress continues unchanged.
- R7: The first byte of each block becomes available 80 cycles after the edge that accepted `start`, or after the edge that accepted the previous block's last byte.
- R8: While emitting, `out_valid` equals `in_valid` and `in_ready` equals `out_ready`. A byte moves only when both valid and ready are 1.
- R9: `busy` stays 1 from the accepted `start` until the edge that transfers the last byte, and falls at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a message (sampled when idle) |
| key | input | 256 | Key, word i at bits 32*i+:32 |
| ctr_nonce | input | 128 | Block counter (bits 31:0) and nonce words |
| msg_len | input | LEN_W | Number of bytes in the message |
| busy | output | 1 | Message in progress |
| in_data | input | 8 | Input byte |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Engine accepts the input byte |
| out_data | output | 8 | Input byte XOR keystream byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts the output byte |

## Verification
The critical cycle is the one in which the last byte of a message is also byte 63 of a block. In that cycle the end of the message and the advance of the block counter fall due together. Message end must win, so that no further permutation starts. Lengths of 64 and 128 bytes provoke this case, and a 130-byte message with the counter at 0xFFFFFFFF crosses the counter wrap. The case is judged by `busy` falling at that exact transfer, by the scoreboard holding no leftover expected bytes, and by `out_valid` staying low while the bench keeps offering input afterwards.

// File: rtl/chacha_xor_engine.sv
module chacha_xor_engine #(
  parameter int ROUNDS = 20,
  parameter int LEN_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [255:0]     key,
  input  logic [127:0]     ctr_nonce,
  input  logic [LEN_W-1:0] msg_len,
  output logic             busy,
  input  logic [7:0]       in_data,
  input  logic             in_valid,
  output logic             in_ready,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready
);
  localparam int QR_TOTAL = ROUNDS * 4;
  localparam int QW = $clog2(QR_TOTAL);
  localparam logic [QW-1:0] QR_LAST = QW'(QR_TOTAL - 1);

  typedef enum logic [1:0] {IDLE, MIX, EMIT} mode_t;
  mode_t mode;

  logic [31:0] w [16];
  logic [31:0] o [16];
  logic [31:0] init_w [16];
  logic [QW-1:0] qc;
  logic [5:0] bpos;
  logic [LEN_W-1:0] left;

  for (genvar i = 0; i < 16; i++) begin : g_init
    if (i == 0) begin : g_c0
      assign init_w[i] = 32'h61707865;
    end else if (i == 1) begin : g_c1
      assign init_w[i] = 32'h3320646e;
    end else if (i == 2) begin : g_c2
      assign init_w[i] = 32'h79622d32;
    end else if (i == 3) begin : g_c3
      assign init_w[i] = 32'h6b206574;
    end else if (i < 12) begin : g_key
      assign init_w[i] = key[32*(i-4) +: 32];
    end else begin : g_cn
      assign init_w[i] = ctr_nonce[32*(i-12) +: 32];
    end
  end

  function automatic logic [31:0] rol(input logic [31:0] v, input int n);
    return (v << n) | (v >> (32 - n));
  endfunction

  logic [1:0] lane, sb, sc, sd;
  logic diag;
  logic [3:0] ia, ib, ic, id;
  assign lane = qc[1:0];
  assign diag = qc[2];
  assign sb = lane + {1'b0, diag};
  assign sc = lane + {diag, 1'b0};
  assign sd = lane + {diag, diag};
  assign ia = {2'd0, lane};
  assign ib = {2'd1, sb};
  assign ic = {2'd2, sc};
  assign id = {2'd3, sd};

  logic [31:0] a1, b1, c1, d1, a2, b2, c2, d2;
  always_comb begin
    a1 = w[ia] + w[ib];
    d1 = rol(w[id] ^ a1, 16);
    c1 = w[ic] + d1;
    b1 = rol(w[ib] ^ c1, 12);
    a2 = a1 + b1;
    d2 = rol(d1 ^ a2, 8);
    c2 = c1 + d2;
    b2 = rol(b1 ^ c2, 7);
  end

  logic [31:0] kword;
  logic [7:0] kbyte;
  logic xfer;
  assign kword = w[bpos[5:2]] + o[bpos[5:2]];
  assign kbyte = kword[{bpos[1:0], 3'b000} +: 8];

  assign busy      = (mode != IDLE);
  assign in_ready  = (mode == EMIT) && out_ready;
  assign out_valid = (mode == EMIT) && in_valid;
  assign out_data  = in_data ^ kbyte;
  assign xfer      = (mode == EMIT) && in_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= IDLE;
      qc   <= '0;
      bpos <= '0;
      left <= '0;
      for (int i = 0; i < 16; i++) begin
        w[i] <= '0;
        o[i] <= '0;
      end
    end else begin
      case (mode)
        IDLE: if (start && msg_len != '0) begin
          for (int i = 0; i < 16; i++) begin
            w[i] <= init_w[i];
            o[i] <= init_w[i];
          end
          left <= msg_len;
          qc   <= '0;
          bpos <= '0;
          mode <= MIX;
        end
        MIX: begin
          w[ia] <= a2;
          w[ib] <= b2;
          w[ic] <= c2;
          w[id] <= d2;
          if (qc == QR_LAST) begin
            qc   <= '0;
            mode <= EMIT;
          end else begin
            qc <= qc + 1'b1;
          end
        end
        EMIT: if (xfer) begin
          left <= left - 1'b1;
          bpos <= bpos + 1'b1;
          if (left == LEN_W'(1)) begin
            mode <= IDLE;
          end else if (bpos == 6'd63) begin
            for (int i = 0; i < 16; i++) w[i] <= o[i];
            w[12] <= o[12] + 32'd1;
            o[12] <= o[12] + 32'd1;
            mode  <= MIX;
          end
        end
        default: mode <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/chacha_xor_engine_chk.sv
module chacha_xor_engine_chk #(
  parameter int LEN_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [LEN_W-1:0] msg_len,
  input logic             busy,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!out_valid && !in_ready));

  assert_zero_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && msg_len == '0) |=> !busy);

  assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && msg_len != '0) |=> (busy && !out_valid));

  assert_backpressure_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !out_ready) |-> !in_ready);

  assert_no_early_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(out_valid && out_ready)) |=> busy);
endmodule

bind chacha_xor_engine chacha_xor_engine_chk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .msg_len(msg_len), .busy(busy),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid), .out_ready(out_ready)
);

// File: tb/chacha_xor_engine_test.sv
module chacha_xor_engine_test;
  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [255:0] key = '0;
  logic [127:0] ctr_nonce = '0;
  logic [31:0] msg_len = '0;
  logic busy;
  logic [7:0] in_data = '0;
  logic in_valid = 0;
  logic in_ready;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1;

  int checks = 0;
  int errors = 0;
  bit thr_g = 0;
  int cyc = 0;
  logic [7:0] exp_q[$];
  string cur_tag = "R2";

  always #10 clk = ~clk;

  chacha_xor_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .key(key), .ctr_nonce(ctr_nonce),
    .msg_len(msg_len), .busy(busy), .in_data(in_data), .in_valid(in_valid),
    .in_ready(in_ready), .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] rl(input logic [31:0] v, input int n);
    logic [63:0] t;
    t = {v, v} >> (32 - n);
    return t[31:0];
  endfunction

  function automatic logic [127:0] qrf(input logic [31:0] a, b, c, d);
    a = a + b; d = rl(d ^ a, 16);
    c = c + d; b = rl(b ^ c, 12);
    a = a + b; d = rl(d ^ a, 8);
    c = c + d; b = rl(b ^ c, 7);
    return {a, b, c, d};
  endfunction

  function automatic logic [511:0] ref_block(input logic [255:0] k, input logic [127:0] cn);
    logic [31:0] s[16];
    logic [31:0] x[16];
    logic [127:0] t;
    logic [511:0] r;
    s[0] = 32'h61707865; s[1] = 32'h3320646e; s[2] = 32'h79622d32; s[3] = 32'h6b206574;
    for (int i = 0; i < 8; i++) s[4+i] = k[32*i +: 32];
    for (int j = 0; j < 4; j++) s[12+j] = cn[32*j +: 32];
    for (int i = 0; i < 16; i++) x[i] = s[i];
    for (int dr = 0; dr < 10; dr++) begin
      for (int l = 0; l < 4; l++) begin
        t = qrf(x[l], x[4+l], x[8+l], x[12+l]);
        {x[l], x[4+l], x[8+l], x[12+l]} = t;
      end
      for (int l = 0; l < 4; l++) begin
        t = qrf(x[l], x[4+(l+1)%4], x[8+(l+2)%4], x[12+(l+3)%4]);
        {x[l], x[4+(l+1)%4], x[8+(l+2)%4], x[12+(l+3)%4]} = t;
      end
    end
    for (int i = 0; i < 16; i++) r[32*i +: 32] = x[i] + s[i];
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    out_ready = thr_g ? (cyc % 3 != 1) : 1'b1;
  end

  always begin
    @(negedge clk);
    #9;
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(0, {cur_tag, " unexpected byte"}, out_data, 0);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        check(out_data == e, {cur_tag, " byte"}, out_data, e);
      end
    end
  end

  task automatic run_msg(input logic [255:0] k, input logic [127:0] cn, input int len,
                         input bit thr, input bit poke, input string tag);
    logic [7:0] din[$];
    logic [511:0] ks;
    int idx, it, first;
    ks = '0;
    cur_tag = tag;
    thr_g = thr;
    for (int n = 0; n < len; n++) begin
      logic [7:0] d;
      if (n % 64 == 0) ks = ref_block(k, {cn[127:32], cn[31:0] + 32'(n / 64)});
      d = 8'(n * 13 + len + 5);
      din.push_back(d);
      exp_q.push_back(d ^ ks[8*(n%64) +: 8]);
    end
    @(negedge clk);
    key = k; ctr_nonce = cn; msg_len = 32'(len); start = 1;
    in_valid = 1; in_data = din[0];
    #9;
    idx = 0; it = 0; first = -1;
    while (idx < len && it < 20000) begin
      @(negedge clk);
      start = poke && idx == 10;
      key = start ? ~k : k;
      msg_len = start ? 32'd5 : 32'(len);
      in_valid = !(thr && it % 5 == 3);
      in_data = din[idx];
      #9;
      it++;
      if (out_valid && first < 0) first = it;
      if (in_valid && in_ready) idx++;
    end
    @(negedge clk);
    start = 0;
    #9;
    check(busy == 0, {tag, " R9 busy after last byte"}, busy, 0);
    check(exp_q.size() == 0, {tag, " R4 byte count"}, exp_q.size(), 0);
    if (!thr) check(first - 1 == 80, {tag, " R7 first-byte latency"}, first - 1, 80);
    begin
      bit quiet;
      quiet = 1;
      for (int q = 0; q < 3; q++) begin
        @(negedge clk); #9;
        if (out_valid || in_ready) quiet = 0;
      end
      check(quiet, {tag, " R4 no bytes past length"}, !quiet, 0);
    end
    @(negedge clk);
    in_valid = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [255:0] k1, k2;
    k1 = {32'h1f1e1d1c, 32'h1b1a1918, 32'h17161514, 32'h13121110,
          32'h0f0e0d0c, 32'h0b0a0908, 32'h07060504, 32'h03020100};
    k2 = {8{32'hdeadbeef}} ^ {k1[127:0], k1[255:128]};
    in_valid = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #9;
    check(busy == 0 && out_valid == 0 && in_ready == 0, "R1 reset state",
          {busy, out_valid, in_ready}, 0);
    @(negedge clk);
    in_valid = 0;

    run_msg(k1, {32'h00000000, 32'h4a000000, 32'h09000000, 32'h00000001}, 64, 0, 0, "R2");
    run_msg(k2, {32'h11111111, 32'h22222222, 32'h33333333, 32'h00000007}, 200, 1, 0, "R3");
    run_msg(k1, {32'h0, 32'h0, 32'h0, 32'h5}, 1, 0, 0, "R4");
    run_msg(k2, {32'h01234567, 32'h89abcdef, 32'h00000000, 32'hffffffff}, 130, 0, 0, "R3");
    run_msg(k1, {32'h5, 32'h6, 32'h7, 32'h8}, 100, 0, 1, "R6");
    run_msg(k2, {32'h9, 32'ha, 32'hb, 32'hc}, 128, 1, 0, "R8");

    begin
      bit quiet;
      quiet = 1;
      @(negedge clk);
      start = 1; msg_len = 0; in_valid = 1; thr_g = 0;
      #9;
      for (int q = 0; q < 20; q++) begin
        @(negedge clk);
        start = 0;
        #9;
        if (busy || out_valid || in_ready) quiet = 0;
      end
      check(quiet, "R5 zero-length request", !quiet, 0);
      @(negedge clk);
      in_valid = 0;
    end

    run_msg(k1, {32'h0, 32'h0, 32'h0, 32'h0}, 64, 0, 0, "R7");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule